// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store request into the ordered list of per-element byte addresses that the memory side consumes. A request carries a base address, a stride, an addressing mode, an element width and the active vector length. After it is accepted, the generator emits one address per cycle over a valid/ready handshake and raises a one-cycle completion pulse once the final address has been taken.

There are three ways to form an address. In contiguous mode, successive elements sit one element size apart. In strided mode the distance is a signed element count scaled to bytes. In gather/scatter mode every element is the base plus a byte offset read from an index vector. That offset arrives through a combinational register-file read port, which the generator steers with an element selector. The element count is set at run time. A count of zero finishes at once, and a count above the maximum vector length is cut down to that maximum.

Top module: `vec_addr_gen`

## Requirements
- R1: Mode code 2'b00 (contiguous), and the spare code 2'b11 which acts the same way, gives address i = base + i * B, where B = 1 << width code (width code 00 = 1 byte, 01 = 2, 10 = 4, 11 = 8). Addresses wrap modulo 2^32.
- R2: Mode code 2'b01 (strided) gives address i = base + i * (stride << width code). The stride is a two's-complement element count, and addresses wrap modulo 2^32.
- R3: Mode code 2'b10 (gather/scatter) drives idx_sel = i and idx_rd_en high, and gives address i = base + idx_rd_data. The index data is a byte offset and is not scaled.
- R4: The number of addresses issued equals min(req_vl, MAX_VL).
- R5: An accepted request with req_vl = 0 issues no address. done is high in the cycle after acceptance.
- R6: While out_valid is high and out_ready is low, out_valid stays high and idx_sel holds its value. In the contiguous and strided modes out_addr also holds.
- R7: done is high for exactly one cycle. That cycle follows the clock edge at which the last address is accepted.
- R8: req_ready is high only while no vector is in progress. A request presented during a run is ignored and does not start a new run.
- R9: After reset, req_ready = 1, out_valid = 0 and done = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Generator idle and able to take a request |
| req_base | input | ADDR_W | Base byte address |
| req_stride | input | ADDR_W | Signed stride in elements (strided mode) |
| req_mode | input | 2 | Addressing mode code |
| req_width | input | 2 | Element width code |
| req_vl | input | VL_W | Requested element count |
| out_valid | output | 1 | Address available |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | ADDR_W | Element byte address |
| idx_rd_en | output | 1 | Index read port enable |
| idx_sel | output | SEL_W | Element number presented to the index read port |
| idx_rd_data | input | ADDR_W | Index value (byte offset) for idx_sel |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the step register or the running address goes wrong, every address after the first in the vector shows the error, starting with the second accepted beat. A fault in the element counter or the length clamp shows up as a vector that is one or more beats short or long. It can also show as a done pulse that arrives early, late or not at all, and this appears at the end of that same vector. A stall that lets internal state move is visible as a changed address or selector on the very next cycle of backpressure. A busy flag that accepts a request it should ignore produces a run that continues past the expected completion.

// File: rtl/vag_pkg.sv
package vag_pkg;
   typedef enum logic [1:0] {
      AM_UNIT   = 2'b00,
      AM_STRIDE = 2'b01,
      AM_INDEX  = 2'b10,
      AM_SPARE  = 2'b11
   } amode_e;

   typedef enum logic [1:0] {
      EW_8  = 2'b00,
      EW_16 = 2'b01,
      EW_32 = 2'b10,
      EW_64 = 2'b11
   } ewidth_e;

   localparam int unsigned N_WIDTHS = 4;
endpackage

// File: rtl/vag_step_calc.sv
module vag_step_calc
   import vag_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] stride_i,
   input  logic [1:0]        width_i,
   input  logic [1:0]        mode_i,
   output logic [ADDR_W-1:0] step_o
);
   logic [ADDR_W-1:0] unit_tbl [N_WIDTHS];
   logic [ADDR_W-1:0] strd_tbl [N_WIDTHS];

   for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
      assign unit_tbl[g] = ADDR_W'(1) << g;
      assign strd_tbl[g] = stride_i << g;
   end

   always_comb begin
      unique case (amode_e'(mode_i))
         AM_STRIDE: step_o = strd_tbl[width_i];
         AM_INDEX:  step_o = '0;
         default:   step_o = unit_tbl[width_i];
      endcase
   end
endmodule

// File: rtl/vag_elem_ctr.sv
module vag_elem_ctr #(
   parameter int unsigned MAX_VL = 64,
   parameter int unsigned VL_W   = $clog2(MAX_VL + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [VL_W-1:0] len_i,
   input  logic            adv_i,
   output logic            zero_o,
   output logic            last_o,
   output logic [VL_W-1:0] cnt_o
);
   localparam logic [VL_W-1:0] MAX_C = VL_W'(MAX_VL);

   logic [VL_W-1:0] len_c;
   logic [VL_W-1:0] cnt_q;
   logic [VL_W-1:0] len_q;

   assign len_c  = (len_i > MAX_C) ? MAX_C : len_i;
   assign zero_o = (len_c == '0);
   assign last_o = (cnt_q == len_q - VL_W'(1));
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= '0;
      end else if (load_i) begin
         cnt_q <= '0;
         len_q <= len_c;
      end else if (adv_i) begin
         cnt_q <= cnt_q + VL_W'(1);
      end
   end
endmodule

// File: rtl/vag_addr_path.sv
module vag_addr_path #(
   parameter int unsigned ADDR_W   = 32,
   parameter bit          INDEX_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] step_i,
   input  logic              adv_i,
   input  logic              indexed_i,
   input  logic [ADDR_W-1:0] idx_data_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] acc_q;
   logic [ADDR_W-1:0] step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         acc_q  <= '0;
         step_q <= '0;
      end else if (load_i) begin
         base_q <= base_i;
         acc_q  <= base_i;
         step_q <= step_i;
      end else if (adv_i) begin
         acc_q  <= acc_q + step_q;
      end
   end

   if (INDEX_EN) begin : g_gather
      assign addr_o = indexed_i ? (base_q + idx_data_i) : acc_q;
   end else begin : g_linear
      logic unused_idx;
      assign unused_idx = ^{indexed_i, idx_data_i, base_q};
      assign addr_o = acc_q;
   end
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
   import vag_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned MAX_VL   = 64,
   parameter bit          INDEX_EN = 1'b1,
   localparam int unsigned VL_W    = $clog2(MAX_VL + 1),
   localparam int unsigned SEL_W   = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [ADDR_W-1:0] req_stride,
   input  logic [1:0]        req_mode,
   input  logic [1:0]        req_width,
   input  logic [VL_W-1:0]   req_vl,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic              idx_rd_en,
   output logic [SEL_W-1:0]  idx_sel,
   input  logic [ADDR_W-1:0] idx_rd_data,
   output logic              done
);
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("vec_addr_gen: ADDR_W must be at least 8");
   end
   if (MAX_VL < 2) begin : g_bad_max_vl
      $error("vec_addr_gen: MAX_VL must be at least 2");
   end

   logic              busy_q;
   logic              done_q;
   amode_e            mode_q;
   logic [1:0]        width_q;
   logic              accept;
   logic              fire;
   logic              zero_w;
   logic              last_w;
   logic [VL_W-1:0]   cnt_w;
   logic [ADDR_W-1:0] step_w;

   assign req_ready = !busy_q;
   assign out_valid = busy_q;
   assign accept    = req_valid && !busy_q;
   assign fire      = busy_q && out_ready;
   assign done      = done_q;
   assign idx_sel   = cnt_w[SEL_W-1:0];
   assign idx_rd_en = busy_q && (mode_q == AM_INDEX);

   vag_step_calc #(.ADDR_W(ADDR_W)) u_step (
      .stride_i (req_stride),
      .width_i  (req_width),
      .mode_i   (req_mode),
      .step_o   (step_w)
   );

   vag_elem_ctr #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .len_i  (req_vl),
      .adv_i  (fire),
      .zero_o (zero_w),
      .last_o (last_w),
      .cnt_o  (cnt_w)
   );

   vag_addr_path #(.ADDR_W(ADDR_W), .INDEX_EN(INDEX_EN)) u_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .base_i     (req_base),
      .step_i     (step_w),
      .adv_i      (fire),
      .indexed_i  (mode_q == AM_INDEX),
      .idx_data_i (idx_rd_data),
      .addr_o     (out_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         mode_q  <= AM_UNIT;
         width_q <= 2'b00;
      end else begin
         done_q <= (accept && zero_w) || (fire && last_w);
         if (accept) begin
            busy_q  <= !zero_w;
            mode_q  <= amode_e'(req_mode);
            width_q <= req_width;
         end else if (fire && last_w) begin
            busy_q  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vag_checker.sv
module vag_checker #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned MAX_VL = 64,
   localparam int unsigned VL_W  = $clog2(MAX_VL + 1),
   localparam int unsigned SEL_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_mode,
   input logic [VL_W-1:0]   req_vl,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_addr,
   input logic              idx_rd_en,
   input logic [SEL_W-1:0]  idx_sel,
   input logic              done,
   input logic [1:0]        mode_q,
   input logic [1:0]        width_q,
   input logic              last_w
);
   AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !last_w && mode_q == 2'b00)
      |=> out_addr == $past(out_addr) + (ADDR_W'(1) << width_q)); // R1

   AST_IDX_START: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_mode == 2'b10 && req_vl != '0)
      |=> (idx_sel == '0 && idx_rd_en)); // R3

   AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_vl == '0) |=> (done && !out_valid)); // R5

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready)
      |=> (out_valid && $stable(idx_sel) && (mode_q == 2'b10 || $stable(out_addr)))); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && last_w) |=> done); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (req_ready && !out_valid)); // R8
endmodule

bind vec_addr_gen vag_checker #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_mode  (req_mode),
   .req_vl    (req_vl),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_addr  (out_addr),
   .idx_rd_en (idx_rd_en),
   .idx_sel   (idx_sel),
   .done      (done),
   .mode_q    (mode_q),
   .width_q   (width_q),
   .last_w    (last_w)
);

// File: tb/vec_addr_gen_tb_top.sv
module vec_addr_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 32;
   localparam int MVL  = 64;
   localparam int VLW  = $clog2(MVL + 1);
   localparam int SW   = $clog2(MVL);
   localparam int NVEC = 11;

   typedef struct packed {
      logic [1:0]     mode;
      logic [1:0]     width;
      logic [31:0]    base;
      logic [31:0]    stride;
      logic [VLW-1:0] vl;
      logic           bp;
      logic           intrude;
      logic [VLW-1:0] exp_n;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{2'b00, 2'b00, 32'h0000_1000, 32'h0,         7'd5,   1'b0, 1'b0, 7'd5},
      '{2'b00, 2'b11, 32'hFFFF_FFF0, 32'h0,         7'd4,   1'b1, 1'b0, 7'd4},
      '{2'b01, 2'b10, 32'h0000_2000, 32'd3,         7'd8,   1'b1, 1'b0, 7'd8},
      '{2'b01, 2'b01, 32'h0000_0008, 32'hFFFF_FFFE, 7'd6,   1'b0, 1'b1, 7'd6},
      '{2'b10, 2'b10, 32'h0000_8000, 32'h0,         7'd10,  1'b1, 1'b0, 7'd10},
      '{2'b10, 2'b00, 32'h0000_0000, 32'h0,         7'd64,  1'b0, 1'b0, 7'd64},
      '{2'b00, 2'b10, 32'h0000_4000, 32'h0,         7'd100, 1'b1, 1'b0, 7'd64},
      '{2'b00, 2'b00, 32'h0000_0100, 32'h0,         7'd0,   1'b0, 1'b0, 7'd0},
      '{2'b11, 2'b01, 32'h0000_0040, 32'h0,         7'd3,   1'b0, 1'b0, 7'd3},
      '{2'b01, 2'b00, 32'h0000_0777, 32'h0,         7'd3,   1'b1, 1'b0, 7'd3},
      '{2'b10, 2'b11, 32'h0000_0200, 32'h0,         7'd0,   1'b0, 1'b0, 7'd0}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_ready;
   logic [AW-1:0]  req_base = '0;
   logic [AW-1:0]  req_stride = '0;
   logic [1:0]     req_mode = '0;
   logic [1:0]     req_width = '0;
   logic [VLW-1:0] req_vl = '0;
   logic           out_valid;
   logic           out_ready = 1'b0;
   logic [AW-1:0]  out_addr;
   logic           idx_rd_en;
   logic [SW-1:0]  idx_sel;
   logic [AW-1:0]  idx_rd_data;
   logic           done;

   int n_chk = 0;
   int n_bad = 0;
   int cyc_total = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [31:0] idx_val(input int i);
      if (i % 2 == 1) return 32'(-(i * 8));
      return 32'(i * 13 + 32'h40);
   endfunction

   always_comb idx_rd_data = idx_val(int'(idx_sel));

   vec_addr_gen #(.ADDR_W(AW), .MAX_VL(MVL)) dut_i (
      .clk, .rst_n, .req_valid, .req_ready, .req_base, .req_stride,
      .req_mode, .req_width, .req_vl, .out_valid, .out_ready, .out_addr,
      .idx_rd_en, .idx_sel, .idx_rd_data, .done
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_addr(input vec_t v, input int i);
      case (v.mode)
         2'b01:   return v.base + 32'(i) * (v.stride << v.width);
         2'b10:   return v.base + idx_val(i);
         default: return v.base + (32'(i) << v.width);
      endcase
   endfunction

   task automatic run_vec(input vec_t v);
      int n = 0;
      int cyc = 0;
      logic stalled = 1'b0;
      logic [31:0] held_addr = '0;
      logic [SW-1:0] held_sel = '0;
      string tag;
      tag = (v.mode == 2'b10) ? "R3" : (v.mode == 2'b01) ? "R2" : "R1";
      @(negedge clk);
      chk("R8", "ready while idle", 32'(req_ready), 32'd1);
      req_base = v.base; req_stride = v.stride; req_mode = v.mode;
      req_width = v.width; req_vl = v.vl; req_valid = 1'b1;
      @(negedge clk);
      req_valid = v.intrude;
      if (v.intrude) begin
         req_base = 32'hDEAD_0000; req_mode = 2'b00; req_vl = 7'd9;
      end
      while (!done && cyc < 2000) begin
         if (out_valid) begin
            if (stalled) begin
               chk("R6", "held selector", 32'(idx_sel), 32'(held_sel));
               if (v.mode != 2'b10) chk("R6", "held address", out_addr, held_addr);
            end
            out_ready = v.bp ? (cyc % 3 != 1) : 1'b1;
            if (out_ready) begin
               chk(tag, "address", out_addr, exp_addr(v, n));
               if (v.mode == 2'b10) chk("R3", "selector", 32'(idx_sel), 32'(n));
               n++;
               if (n == int'(v.exp_n)) req_valid = 1'b0;
               stalled = 1'b0;
            end else begin
               stalled = 1'b1;
               held_addr = out_addr;
               held_sel = idx_sel;
            end
         end else begin
            out_ready = 1'b0;
         end
         cyc++;
         @(negedge clk);
      end
      out_ready = 1'b0;
      req_valid = 1'b0;
      chk("R4", "element count", 32'(n), 32'(v.exp_n));
      chk(v.exp_n == 0 ? "R5" : "R7", "done seen", 32'(done), 32'd1);
      chk("R5", "no valid at done", 32'(out_valid), 32'd0);
      @(negedge clk);
      chk("R7", "done one cycle", 32'(done), 32'd0);
      chk("R8", "no run restarted", 32'(out_valid), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9", "reset ready", 32'(req_ready), 32'd1);
      chk("R9", "reset valid", 32'(out_valid), 32'd0);
      chk("R9", "reset done", 32'(done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "idle after reset", 32'(done), 32'd0);
      for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);
      // R5 back-to-back zero-length requests
      run_vec(VEC[7]);
      run_vec(VEC[10]);
      // R6 R1 long stall on first beat then drain
      @(negedge clk);
      req_base = 32'h0000_3000; req_mode = 2'b00; req_width = 2'b01;
      req_vl = 7'd2; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) begin
         chk("R6", "stalled valid", 32'(out_valid), 32'd1);
         chk("R6", "stalled address", out_addr, 32'h0000_3000);
         @(negedge clk);
      end
      out_ready = 1'b1;
      @(negedge clk);
      chk("R1", "second address", out_addr, 32'h0000_3002);
      @(negedge clk);
      out_ready = 1'b0;
      chk("R7", "done after stall", 32'(done), 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total > 100000) begin
         n_bad++;
         $display("FAIL R7 watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule